// File: doc/BRIEF.md
# Banked Memory Window Mapper

A 16-bit network controller sees its buffer memory as one linear address space, while the host reaches that memory through a small window of 8 KB. This block turns a controller-side address (a base address plus an offset counted in 16-bit words) into a bank number and a byte offset inside the window. It keeps the number of the bank that is currently mapped and issues a bank-select register write only when a request needs a different bank.

A configuration port loads the window base. The block accepts a base only if it lies in the permitted range. An accepted base always maps bank 0 and records bank 0 as the current bank. Requests are single-cycle strobes. The block answers each request with a one-cycle `ready` pulse, and `win_ofs` is valid while `ready` is high. A bank-register write, when one is needed, comes in the cycle just before `ready`.

The controller has five states:
- `ST_IDLE`: waits for work.
  - IDLE→CFGWR: a configuration with a valid base.
  - IDLE→CFGREJ: a configuration with an invalid base.
  - IDLE→BANKWR: a request whose bank misses the cache.
  - IDLE→DONE: a request whose bank hits the cache.
- `ST_BANKWR`: drives the bank write. BANKWR→DONE.
- `ST_DONE`: pulses `ready`. DONE→IDLE.
- `ST_CFGWR`: writes bank 0 and pulses `cfg_ok`. CFGWR→IDLE.
- `ST_CFGREJ`: pulses `cfg_fail`. CFGREJ→IDLE.

Top module: `bank_window_mapper`

## Requirements
- R1: The byte address is `req_base + 2*req_word_ofs`, truncated to 20 bits. The `win_ofs` output presented with `ready` is bits 12:0 of that address.
- R2: The bank is the byte address shifted right by 13. A bank write drives `bsel_val`, where bit 7 is the bank-select-enable bit (always 1 during a write) and bits 6:0 are the bank number.
- R3: When the bank of a request equals the cached current bank, no bank write is issued. When it differs, exactly one write is issued and the cache takes the new bank.
- R4: On a cache hit, `ready` is high in the first cycle after the cycle in which `req` was sampled. On a miss, `bsel_we` is high in that first cycle and `ready` is high in the second.
- R5: Reset marks the cache invalid, so the first request after reset always writes the bank register, even for bank 0.
- R6: A configuration base is accepted when clearing bits 16:13 leaves 0xC0000. The cycle after `cfg_valid`, the block then raises `cfg_ok` and `bsel_we` with `bsel_val` = 0x80. `win_sel` takes base bits 16:13, and the cache becomes bank 0.
- R7: Any other configuration base raises `cfg_fail` for one cycle and issues no bank write. The cached bank and `win_sel` stay unchanged.
- R8: A request whose byte address is odd sets `misalign`. The flag stays set until reset.
- R9: When `cfg_valid` and `req` are sampled in the same idle cycle, the configuration is served and the request is dropped, so no `ready` follows it.
- R10: `req` and `cfg_valid` are ignored while the block is not in `ST_IDLE`.
- R11: After reset, `ready`, `bsel_we`, `bsel_val`, `cfg_ok`, `cfg_fail`, `misalign`, `win_sel` and `win_ofs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration strobe |
| cfg_base | input | 20 | Window base offered for configuration |
| req | input | 1 | Translation request strobe |
| req_base | input | 20 | Byte base address of the request |
| req_word_ofs | input | 16 | Offset in 16-bit words |
| win_ofs | output | 13 | Byte offset inside the window, valid with ready |
| bsel_we | output | 1 | Bank-select register write strobe |
| bsel_val | output | 8 | Bank-select value: bit 7 is the enable bit, bits 6:0 are the bank |
| ready | output | 1 | Translation complete |
| misalign | output | 1 | Sticky flag for an odd byte address |
| cfg_ok | output | 1 | Configuration accepted |
| cfg_fail | output | 1 | Configuration rejected |
| win_sel | output | 4 | Window select bits taken from the accepted base |

## Verification
Configuration and translation compete for the same idle cycle. The bench asserts `cfg_valid` and `req` on the same edge. It then judges that only `cfg_ok` and the bank-0 write follow, with no `ready`. A later request for the same bank must complete without a write, which shows the request left no trace. A misaligned request that also misses the cache checks that the sticky flag and the bank write come out of one acceptance. A configuration strobe sent while a bank write is in flight must produce neither `cfg_ok` nor `cfg_fail`.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BANKWR,
        ST_DONE,
        ST_CFGWR,
        ST_CFGREJ
    } map_state_t;
endpackage

// File: rtl/addr_split.sv
module addr_split #(
    parameter int ADDR_W   = 20,
    parameter int OFS_W    = 16,
    parameter int WIN_BITS = 13
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [OFS_W-1:0]           word_ofs,
    output logic [ADDR_W-WIN_BITS-1:0] bank,
    output logic [WIN_BITS-1:0]        ofs,
    output logic                       odd
);
    localparam int BANK_W = ADDR_W - WIN_BITS;

    logic [ADDR_W-1:0] dbl;
    logic [ADDR_W-1:0] byte_addr;

    // word offset doubled: accesses are always 16 bits wide
    assign dbl       = ADDR_W'({word_ofs, 1'b0});
    assign byte_addr = base + dbl;
    assign bank      = byte_addr[ADDR_W-1 -: BANK_W];
    assign ofs       = byte_addr[WIN_BITS-1:0];
    assign odd       = byte_addr[0];
endmodule

// File: rtl/base_check.sv
module base_check #(
    parameter int          ADDR_W    = 20,
    parameter int          WIN_BITS  = 13,
    parameter int          SEL_W     = 4,
    parameter logic [19:0] WIN_FIXED = 20'hC0000
) (
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              good,
    output logic [SEL_W-1:0]  sel
);
    localparam logic [ADDR_W-1:0] SEL_MASK =
        ADDR_W'(((1 << SEL_W) - 1) << WIN_BITS);
    localparam logic [ADDR_W-1:0] FIXED = ADDR_W'(WIN_FIXED);

    assign good = (cfg_base & ~SEL_MASK) == FIXED;
    assign sel  = cfg_base[WIN_BITS +: SEL_W];
endmodule

// File: rtl/bank_cache.sv
module bank_cache #(
    parameter int BANK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [BANK_W-1:0] probe_bank,
    output logic              hit
);
    logic [BANK_W-1:0] cur_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            cur_q   <= load_bank;
            valid_q <= 1'b1;
        end
    end

    assign hit = valid_q && (cur_q == probe_bank);
endmodule

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
    import mapper_pkg::*;
#(
    parameter int BANK_W   = 7,
    parameter int WIN_BITS = 13,
    parameter int SEL_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                cfg_valid,
    input  logic                cfg_good,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic                hit,
    input  logic [BANK_W-1:0]   calc_bank,
    input  logic [WIN_BITS-1:0] calc_ofs,
    input  logic                calc_odd,
    output logic                cache_load,
    output logic [BANK_W-1:0]   cache_bank,
    output logic                ready,
    output logic                bsel_we,
    output logic [BANK_W:0]     bsel_val,
    output logic [WIN_BITS-1:0] win_ofs,
    output logic                misalign,
    output logic                cfg_ok,
    output logic                cfg_fail,
    output logic [SEL_W-1:0]    win_sel
);
    map_state_t state_q, state_d;

    logic [BANK_W-1:0]   bank_q;
    logic [WIN_BITS-1:0] ofs_q;
    logic                misalign_q;
    logic [SEL_W-1:0]    win_sel_q;

    logic idle, take_cfg, take_req;

    assign idle     = (state_q == ST_IDLE);
    assign take_cfg = idle && cfg_valid;
    assign take_req = idle && !cfg_valid && req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_valid)
                    state_d = cfg_good ? ST_CFGWR : ST_CFGREJ;
                else if (req)
                    state_d = hit ? ST_DONE : ST_BANKWR;
            end
            ST_BANKWR: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_CFGWR:  state_d = ST_IDLE;
            ST_CFGREJ: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= '0;
            ofs_q      <= '0;
            misalign_q <= 1'b0;
            win_sel_q  <= '0;
        end else if (take_cfg) begin
            if (cfg_good) begin
                win_sel_q <= cfg_sel;
                bank_q    <= '0;
            end
        end else if (take_req) begin
            bank_q <= calc_bank;
            ofs_q  <= calc_ofs;
            if (calc_odd)
                misalign_q <= 1'b1;
        end
    end

    always_comb begin
        cache_load = (take_cfg && cfg_good) || (take_req && !hit);
        cache_bank = take_cfg ? '0 : calc_bank;
    end

    always_comb begin
        ready    = (state_q == ST_DONE);
        cfg_ok   = (state_q == ST_CFGWR);
        cfg_fail = (state_q == ST_CFGREJ);
        bsel_we  = (state_q == ST_BANKWR) || (state_q == ST_CFGWR);
        bsel_val = bsel_we ? {1'b1, bank_q} : '0;
        win_ofs  = ofs_q;
        misalign = misalign_q;
        win_sel  = win_sel_q;
    end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
    parameter int          ADDR_W    = 20,
    parameter int          OFS_W     = 16,
    parameter int          WIN_BITS  = 13,
    parameter int          SEL_W     = 4,
    parameter logic [19:0] WIN_FIXED = 20'hC0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_valid,
    input  logic [ADDR_W-1:0]            cfg_base,
    input  logic                         req,
    input  logic [ADDR_W-1:0]            req_base,
    input  logic [OFS_W-1:0]             req_word_ofs,
    output logic [WIN_BITS-1:0]          win_ofs,
    output logic                         bsel_we,
    output logic [ADDR_W-WIN_BITS:0]     bsel_val,
    output logic                         ready,
    output logic                         misalign,
    output logic                         cfg_ok,
    output logic                         cfg_fail,
    output logic [SEL_W-1:0]             win_sel
);
    localparam int BANK_W = ADDR_W - WIN_BITS;

    logic [BANK_W-1:0]   calc_bank;
    logic [WIN_BITS-1:0] calc_ofs;
    logic                calc_odd;
    logic                cfg_good;
    logic [SEL_W-1:0]    cfg_sel;
    logic                hit;
    logic                cache_load;
    logic [BANK_W-1:0]   cache_bank;

    addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BITS(WIN_BITS)) u_split (
        .base     (req_base),
        .word_ofs (req_word_ofs),
        .bank     (calc_bank),
        .ofs      (calc_ofs),
        .odd      (calc_odd)
    );

    base_check #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SEL_W(SEL_W),
                 .WIN_FIXED(WIN_FIXED)) u_base (
        .cfg_base (cfg_base),
        .good     (cfg_good),
        .sel      (cfg_sel)
    );

    bank_cache #(.BANK_W(BANK_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cache_load),
        .load_bank  (cache_bank),
        .probe_bank (calc_bank),
        .hit        (hit)
    );

    mapper_ctrl #(.BANK_W(BANK_W), .WIN_BITS(WIN_BITS), .SEL_W(SEL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .cfg_valid  (cfg_valid),
        .cfg_good   (cfg_good),
        .cfg_sel    (cfg_sel),
        .hit        (hit),
        .calc_bank  (calc_bank),
        .calc_ofs   (calc_ofs),
        .calc_odd   (calc_odd),
        .cache_load (cache_load),
        .cache_bank (cache_bank),
        .ready      (ready),
        .bsel_we    (bsel_we),
        .bsel_val   (bsel_val),
        .win_ofs    (win_ofs),
        .misalign   (misalign),
        .cfg_ok     (cfg_ok),
        .cfg_fail   (cfg_fail),
        .win_sel    (win_sel)
    );
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int BANK_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready,
    input logic            bsel_we,
    input logic [BANK_W:0] bsel_val,
    input logic            misalign,
    input logic            cfg_ok,
    input logic            cfg_fail
);
    AST_WRITE_ENABLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        bsel_we |-> bsel_val[BANK_W]); // R2

    AST_MISS_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bsel_we && !cfg_ok) |=> ready); // R4

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R4

    AST_CFG_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |-> (bsel_we && bsel_val[BANK_W-1:0] == '0)); // R6

    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fail |-> (!bsel_we && !cfg_ok)); // R7

    AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign); // R8

    AST_CFG_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok || cfg_fail) |=> !ready); // R9
endmodule

bind bank_window_mapper mapper_checker #(.BANK_W(ADDR_W - WIN_BITS)) i_mapper_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .bsel_we  (bsel_we),
    .bsel_val (bsel_val),
    .misalign (misalign),
    .cfg_ok   (cfg_ok),
    .cfg_fail (cfg_fail)
);

// File: tb/test_bank_window_mapper.sv
module test_bank_window_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [19:0] cfg_base = '0;
    logic        req = 1'b0;
    logic [19:0] req_base = '0;
    logic [15:0] req_word_ofs = '0;
    logic [12:0] win_ofs;
    logic        bsel_we;
    logic [7:0]  bsel_val;
    logic        ready;
    logic        misalign;
    logic        cfg_ok;
    logic        cfg_fail;
    logic [3:0]  win_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // stimulus and expected results: base, word offset, bank, window offset, write
    localparam logic [19:0] V_BASE [NV] = '{20'h00000, 20'h02000, 20'h02000, 20'h02000,
                                             20'h10000, 20'h1FFFE, 20'hFE000, 20'hFFFFE};
    localparam logic [15:0] V_OFS  [NV] = '{16'h0010, 16'h0001, 16'h0FFF, 16'h1000,
                                             16'h8000, 16'h0001, 16'h0FFF, 16'h0002};
    localparam logic [6:0]  V_BANK [NV] = '{7'h00, 7'h01, 7'h01, 7'h02,
                                             7'h10, 7'h10, 7'h7F, 7'h00};
    localparam logic [12:0] V_WOFS [NV] = '{13'h0020, 13'h0002, 13'h1FFE, 13'h0000,
                                             13'h0000, 13'h0000, 13'h1FFE, 13'h0002};
    localparam logic        V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    bank_window_mapper i_bank_window_mapper (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
        .req(req), .req_base(req_base), .req_word_ofs(req_word_ofs),
        .win_ofs(win_ofs), .bsel_we(bsel_we), .bsel_val(bsel_val), .ready(ready),
        .misalign(misalign), .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .win_sel(win_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // request issued for one edge; checks follow the hit or miss timing
    task automatic do_req(input logic [19:0] b, input logic [15:0] o, input logic [6:0] bank,
                          input logic [12:0] wofs, input logic wr, input string tag);
        @(negedge clk);
        req = 1'b1; req_base = b; req_word_ofs = o;
        @(negedge clk);
        req = 1'b0;
        if (wr) begin
            chk({tag, " R3 write issued"}, bsel_we, 1'b1);
            chk({tag, " R2 bank value"}, bsel_val, {1'b1, bank});
            chk({tag, " R4 not ready yet"}, ready, 1'b0);
            @(negedge clk);
        end else begin
            chk({tag, " R3 no write"}, bsel_we, 1'b0);
        end
        chk({tag, " R4 ready"}, ready, 1'b1);
        chk({tag, " R1 window offset"}, win_ofs, wofs);
    endtask

    task automatic do_cfg(input logic [19:0] b, input logic good, input string tag);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_base = b;
        @(negedge clk);
        cfg_valid = 1'b0;
        if (good) begin
            chk({tag, " R6 cfg_ok"}, cfg_ok, 1'b1);
            chk({tag, " R6 bank0 write"}, {bsel_we, bsel_val}, 9'h180);
        end else begin
            chk({tag, " R7 cfg_fail"}, cfg_fail, 1'b1);
            chk({tag, " R7 no write"}, bsel_we, 1'b0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 outputs at reset", {ready, bsel_we, bsel_val, cfg_ok, cfg_fail, misalign, win_sel, win_ofs},
            '0);
        rst_n = 1'b1;

        // R5 first access after reset writes even bank 0
        do_req(20'h00000, 16'h0004, 7'h00, 13'h0008, 1'b1, "R5 first access");
        do_req(20'h00000, 16'h0005, 7'h00, 13'h000A, 1'b0, "R5 then hit");

        // R6 accepted base maps bank 0
        do_cfg(20'hC0000, 1'b1, "R6 base C0000");
        chk("R6 win_sel", win_sel, 4'h0);

        for (int i = 0; i < NV; i++)
            do_req(V_BASE[i], V_OFS[i], V_BANK[i], V_WOFS[i], V_WR[i], $sformatf("R1 vec%0d", i));
        chk("R8 even addresses keep flag clear", misalign, 1'b0);

        // R6 another legal base with all select bits set
        do_cfg(20'hDE000, 1'b1, "R6 base DE000");
        chk("R6 win_sel F", win_sel, 4'hF);
        do_req(20'h02000, 16'h0000, 7'h01, 13'h0000, 1'b1, "R6 cache became bank0");

        // R7 rejected bases leave cache (bank 1) and win_sel untouched
        do_cfg(20'hC1000, 1'b0, "R7 base C1000");
        do_cfg(20'hA0000, 1'b0, "R7 base A0000");
        chk("R7 win_sel kept", win_sel, 4'hF);
        do_req(20'h02000, 16'h0010, 7'h01, 13'h0020, 1'b0, "R7 cache kept");

        // R9 config and request on the same edge
        @(negedge clk);
        cfg_valid = 1'b1; cfg_base = 20'hC2000;
        req = 1'b1; req_base = 20'h06000; req_word_ofs = '0;
        @(negedge clk);
        cfg_valid = 1'b0; req = 1'b0;
        chk("R9 cfg served", {cfg_ok, bsel_we, bsel_val}, 10'h380);
        chk("R9 no ready with cfg", ready, 1'b0);
        @(negedge clk);
        chk("R9 request dropped", ready, 1'b0);
        chk("R9 win_sel 1", win_sel, 4'h1);
        do_req(20'h00000, 16'h0001, 7'h00, 13'h0002, 1'b0, "R9 bank0 hit");

        // R10 config offered while a bank write is in flight
        @(negedge clk);
        req = 1'b1; req_base = 20'h08000; req_word_ofs = '0;
        @(negedge clk);
        req = 1'b0;
        chk("R10 miss write", bsel_we, 1'b1);
        cfg_valid = 1'b1; cfg_base = 20'h00001;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk("R10 ready", ready, 1'b1);
        chk("R10 no cfg_fail", cfg_fail, 1'b0);
        @(negedge clk);
        chk("R10 still no cfg result", {cfg_ok, cfg_fail}, 2'b00);

        // R8 odd address together with a bank miss
        do_req(20'h0A001, 16'h0000, 7'h05, 13'h0001, 1'b1, "R8 odd miss");
        chk("R8 flag set", misalign, 1'b1);
        do_req(20'h0A000, 16'h0002, 7'h05, 13'h0004, 1'b0, "R8 even after");
        chk("R8 flag sticky", misalign, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 R11 reset clears flag", misalign, 1'b0);
        rst_n = 1'b1;
        do_req(20'h0A000, 16'h0002, 7'h05, 13'h0004, 1'b1, "R5 after second reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule